// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the read side of a synchronous memory. A host presents an address while holding the active-low address-valid strobe low, and the block captures that address on the rising clock edge. Once the strobe returns high, the block counts a programmable number of rising edges before it presents the first data word. It then steps one word per clock through a linear burst of 8, 16 or 32 words, or reads on without limit in continuous mode. A linear burst either wraps inside its aligned block or runs straight on past the block boundary. A ready output marks valid data. Its active level can be chosen, and it can lead the first word by one clock.

A 16-bit configuration word is written through a one-cycle write strobe. The latency and burst-length fields accept only legal codes. The latency, ready timing, burst length and wrap settings in force at the moment of address capture apply to that whole burst. The polarity setting acts immediately. Data comes from an internal lookup that depends on the address, so every word can be predicted. The sequencer has three states. IDLE waits for a capture. LAT counts latency edges. DATA streams words. Transitions: any state goes to LAT on a capture edge (chip enable low, strobe low). Any state goes to IDLE while chip enable is high. LAT goes to DATA on the latency edge. DATA goes to IDLE after the last word of a linear burst.

Top module: `burst_read_engine`

## Requirements
- R1: On a rising edge with ce_n low and adv_n low, addr_in is captured as the burst start address. The next clock shows ready inactive and data_out zero.
- R2: The configuration word's bits [3:0] hold the latency code. Codes 0..5 put the first word after the (code+2)th rising edge with adv_n high following capture. Codes 8..13 put it after the (code)th such edge. Word k follows edge N+k.
- R3: A configuration write with latency code 6, 7, 14 or 15 leaves the latency field unchanged. The other fields of that write still take effect.
- R4: Bit 4 sets the ready polarity. When it is 1, ready is high when active. When it is 0, ready is low when active. The inactive level is the opposite of the active level.
- R5: Bit 5 set to 1 makes ready active exactly while data is valid. Bit 5 set to 0 also makes ready active one clock before the first word.
- R6: Bits [8:6] hold the burst length: 000 is continuous, 010 is 8 words, 011 is 16 words and 100 is 32 words. A linear burst shows exactly that many words, then ready goes inactive and data_out returns to zero.
- R7: When bit 9 is 1 and the length is linear, the word address after the start stays inside the aligned block of the burst length. Its low bits count modulo the length and its upper bits are held.
- R8: When bit 9 is 0, successive words use start address +1, +2 and so on, across block boundaries.
- R9: In continuous mode bit 9 has no effect. Words follow at linearly increasing addresses, one per clock, until a new capture or ce_n high.
- R10: A configuration write with a burst-length code of 001, 101, 110 or 111 leaves the length field unchanged.
- R11: A capture during a burst aborts that burst and restarts the latency count from the new address.
- R12: ce_n high on a rising edge ends any burst. From the next clock, ready is inactive and data_out is zero.
- R13: After reset the configuration word is 0x023D (latency code 1101, ready active high and with data, continuous, wrap on). Ready is low and data_out is zero.
- R14: The word at address A is the low DW bits of (A × 40503) XOR 0xA5C3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Burst start address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| data_out | output | DW | Read data, zero when not valid |
| rdy | output | 1 | Ready, polarity set by configuration |

## Verification
A wrong latency count or a bad snapshot of the settings shifts the first ready edge and the first word by one or more cycles, so it shows on the first burst after the fault. A wrong address step shows at the word where the burst crosses a block boundary. For wrap and no-wrap modes this is at most 32 cycles after the data starts. A state machine stuck in DATA shows one cycle after the last word of a linear burst, or one cycle after chip enable rises, as ready still active.

// File: rtl/bre_pkg.sv
package bre_pkg;
    localparam int CFG_W = 16;

    typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} state_t;

    function automatic logic lat_code_ok(input logic [3:0] c);
        return (c <= 4'd5) || (c >= 4'd8 && c <= 4'd13);
    endfunction

    function automatic logic [3:0] lat_to_edges(input logic [3:0] c);
        return (c <= 4'd5) ? c + 4'd2 : c;
    endfunction

    function automatic logic len_code_ok(input logic [2:0] c);
        return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
    endfunction

    function automatic logic [5:0] len_to_words(input logic [2:0] c);
        logic [5:0] w;
        unique case (c)
            3'd2:    w = 6'd8;
            3'd3:    w = 6'd16;
            3'd4:    w = 6'd32;
            default: w = 6'd0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/bre_cfg.sv
module bre_cfg
    import bre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [3:0]       lat_edges,
    output logic             pol,
    output logic             early,
    output logic [5:0]       len_words,
    output logic             wrap
);
    logic [3:0] lat_code_q;
    logic [2:0] len_code_q;
    logic       with_data_q;
    logic       unused_hi;

    assign unused_hi = ^wdata[CFG_W-1:10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_code_q  <= 4'hD;
            pol         <= 1'b1;
            with_data_q <= 1'b1;
            len_code_q  <= 3'd0;
            wrap        <= 1'b1;
        end else if (we) begin
            if (lat_code_ok(wdata[3:0])) lat_code_q <= wdata[3:0];
            if (len_code_ok(wdata[8:6])) len_code_q <= wdata[8:6];
            pol         <= wdata[4];
            with_data_q <= wdata[5];
            wrap        <= wdata[9];
        end
    end

    assign lat_edges = lat_to_edges(lat_code_q);
    assign len_words = len_to_words(len_code_q);
    assign early     = ~with_data_q;
endmodule

// File: rtl/bre_array.sv
module bre_array #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    localparam logic [31:0] MULT = 32'd40503;
    localparam logic [DW-1:0] SALT = DW'(16'hA5C3);

    always_comb begin
        word = DW'(32'(addr) * MULT) ^ SALT;
    end
endmodule

// File: rtl/bre_fsm.sv
module bre_fsm
    import bre_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    input  logic [3:0]    lat_edges,
    input  logic          early,
    input  logic [5:0]    len_words,
    input  logic          wrap,
    output state_t        st,
    output logic [AW-1:0] cur_addr,
    output logic [5:0]    len_s,
    output logic          wrap_s,
    output logic          word_valid,
    output logic          rdy_act
);
    logic [3:0] cnt;
    logic [3:0] lat_s;
    logic       early_s;
    logic [5:0] widx;
    logic [AW-1:0] blk_mask;
    logic [AW-1:0] next_addr;

    always_comb begin
        blk_mask = AW'(len_s) - AW'(1);
        if (wrap_s)
            next_addr = (cur_addr & ~blk_mask) | ((cur_addr + AW'(1)) & blk_mask);
        else
            next_addr = cur_addr + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cnt      <= '0;
            lat_s    <= 4'd13;
            early_s  <= 1'b0;
            len_s    <= '0;
            wrap_s   <= 1'b0;
            widx     <= '0;
            cur_addr <= '0;
        end else if (ce_n) begin
            st <= S_IDLE;
        end else if (!adv_n) begin
            st       <= S_LAT;
            cnt      <= '0;
            cur_addr <= addr_in;
            lat_s    <= lat_edges;
            early_s  <= early;
            len_s    <= len_words;
            wrap_s   <= wrap && (len_words != 6'd0);
        end else begin
            unique case (st)
                S_IDLE: st <= S_IDLE;
                S_LAT: begin
                    cnt <= cnt + 4'd1;
                    if (cnt + 4'd1 == lat_s) begin
                        st   <= S_DATA;
                        widx <= '0;
                    end
                end
                S_DATA: begin
                    if (len_s != 6'd0 && widx == len_s - 6'd1) begin
                        st <= S_IDLE;
                    end else begin
                        widx     <= widx + 6'd1;
                        cur_addr <= next_addr;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        word_valid = 1'b0;
        rdy_act    = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_LAT:  rdy_act = early_s && (cnt + 4'd1 == lat_s - 4'd1 + 4'd1) && (cnt == lat_s - 4'd1);
            S_DATA: begin
                word_valid = 1'b1;
                rdy_act    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import bre_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             adv_n,
    input  logic [AW-1:0]    addr_in,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [DW-1:0]    data_out,
    output logic             rdy
);
    logic [3:0]    lat_edges;
    logic          cfg_pol;
    logic          early;
    logic [5:0]    len_words;
    logic          wrap;
    state_t        st;
    logic [AW-1:0] cur_addr;
    logic [5:0]    len_s;
    logic          wrap_s;
    logic          word_valid;
    logic          rdy_act;
    logic [DW-1:0] word;

    bre_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .lat_edges(lat_edges), .pol(cfg_pol), .early(early),
        .len_words(len_words), .wrap(wrap)
    );

    bre_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
        .addr_in(addr_in), .lat_edges(lat_edges), .early(early),
        .len_words(len_words), .wrap(wrap), .st(st),
        .cur_addr(cur_addr), .len_s(len_s), .wrap_s(wrap_s),
        .word_valid(word_valid), .rdy_act(rdy_act)
    );

    bre_array #(.AW(AW), .DW(DW)) u_array (
        .addr(cur_addr), .word(word)
    );

    assign data_out = word_valid ? word : '0;
    assign rdy      = rdy_act ? cfg_pol : ~cfg_pol;
endmodule

// File: rtl/bre_checker.sv
module bre_checker
    import bre_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          rdy,
    input  logic          cfg_pol,
    input  state_t        st,
    input  logic [AW-1:0] cur_addr,
    input  logic [5:0]    len_s,
    input  logic          wrap_s
);
    logic [AW-1:0] mask;
    assign mask = AW'(len_s) - AW'(1);

    p_capture_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) |=> (rdy != cfg_pol));

    p_ce_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (st == S_IDLE && rdy != cfg_pol));

    p_data_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && $past(st) != S_DATA) |-> ($past(st) == S_LAT && $past(adv_n)));

    p_wrap_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && $past(st) == S_DATA && wrap_s)
            |-> ((cur_addr & ~mask) == ($past(cur_addr) & ~mask)));
endmodule

bind burst_read_engine bre_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .rdy(rdy),
    .cfg_pol(cfg_pol), .st(st), .cur_addr(cur_addr), .len_s(len_s),
    .wrap_s(wrap_s)
);

// File: tb/burst_read_engine_tb.sv
module burst_read_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0;
    logic adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [DW-1:0] data_out;
    logic rdy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [3:0] m_lat = 4'hD;
    logic       m_pol = 1'b1;
    logic       m_wd  = 1'b1;
    logic [2:0] m_len = 3'd0;
    logic       m_wrap = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_read_engine #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
        .addr_in(addr_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .data_out(data_out), .rdy(rdy)
    );

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'd40503;
        return p[DW-1:0] ^ 16'hA5C3;
    endfunction

    function automatic int edges_of(input logic [3:0] c);
        return (c <= 4'd5) ? int'(c) + 2 : int'(c);
    endfunction

    function automatic int words_of(input logic [2:0] c);
        case (c)
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] a, input int k,
                                               input int len, input logic wr);
        logic [AW-1:0] m;
        if (len == 0 || !wr) return a + AW'(k);
        m = AW'(len - 1);
        return (a & ~m) | ((a + AW'(k)) & m);
    endfunction

    task automatic check(input string tag, input logic act, input logic [DW-1:0] d);
        logic er;
        er = act ? m_pol : ~m_pol;
        checks++;
        if (rdy !== er || data_out !== d) begin
            errors++;
            $display("FAIL %s t=%0t rdy=%b data=%h expected rdy=%b data=%h",
                     tag, $time, rdy, data_out, er, d);
        end
    endtask

    task automatic write_cfg(input logic [3:0] lat, input logic pol, input logic wd,
                             input logic [2:0] len, input logic wr);
        cfg_wdata = {6'b0, wr, len, wd, pol, lat};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if ((lat <= 4'd5) || (lat >= 4'd8 && lat <= 4'd13)) m_lat = lat;
        if (len == 3'd0 || len == 3'd2 || len == 3'd3 || len == 3'd4) m_len = len;
        m_pol = pol;
        m_wd = wd;
        m_wrap = wr;
    endtask

    task automatic run_burst(input string tag, input logic [AW-1:0] a, input int edges);
        int n, len;
        logic wr, ea;
        n = edges_of(m_lat);
        len = words_of(m_len);
        wr = m_wrap && (len != 0);
        ea = !m_wd;
        adv_n = 1'b0;
        addr_in = a;
        @(negedge clk);
        adv_n = 1'b1;
        addr_in = $urandom;
        check({tag, " R1"}, 1'b0, '0);
        for (int j = 1; j <= edges; j++) begin
            @(negedge clk);
            if (j >= n && (len == 0 || j - n < len))
                check(tag, 1'b1, exp_word(seq_addr(a, j - n, len, wr)));
            else
                check(tag, ea && (j == n - 1), '0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 reset", 1'b0, '0);

        // R13 defaults, R9 continuous crossing a boundary with wrap bit set
        run_burst("R13 R9 default", 16'h00FE, 13 + 12);

        // R11 restart mid-data
        write_cfg(4'd1, 1'b1, 1'b1, 3'd2, 1'b1);
        run_burst("R11 first", 16'h0105, 5);
        run_burst("R11 restart", 16'h2207, 3 + 10);

        // R12 chip enable abort
        run_burst("R12 pre", 16'h0030, 5);
        ce_n = 1'b1;
        @(negedge clk);
        check("R12 abort", 1'b0, '0);
        ce_n = 1'b0;
        @(negedge clk);
        check("R12 idle", 1'b0, '0);

        // R3 reserved latency ignored, other fields taken (R4 polarity low)
        write_cfg(4'd3, 1'b1, 1'b1, 3'd3, 1'b0);
        write_cfg(4'd7, 1'b0, 1'b0, 3'd2, 1'b1);
        run_burst("R3 R4 R5 R7", 16'h041D, 5 + 10);

        // R10 reserved length ignored
        write_cfg(4'd0, 1'b1, 1'b1, 3'd6, 1'b0);
        run_burst("R10 R8", 16'h00FC, 2 + 12);

        // R6 32-word wrap and no-wrap
        write_cfg(4'd8, 1'b1, 1'b0, 3'd4, 1'b1);
        run_burst("R6 R7 R14", 16'h7FF3, 8 + 35);
        write_cfg(4'd13, 1'b0, 1'b1, 3'd4, 1'b0);
        run_burst("R6 R8", 16'hFFF3, 13 + 35);

        // Random configurations
        for (int i = 0; i < 30; i++) begin
            logic [3:0] lc;
            logic [2:0] ln;
            int len;
            string tag;
            lc = 4'($urandom_range(0, 15));
            ln = 3'($urandom_range(0, 7));
            write_cfg(lc, 1'($urandom), 1'($urandom), ln, 1'($urandom));
            len = words_of(m_len);
            if (len == 0) tag = "R2 R9 rand";
            else if (m_wrap) tag = "R2 R6 R7 rand";
            else tag = "R2 R6 R8 rand";
            run_burst(tag, AW'($urandom), edges_of(m_lat) + ((len == 0) ? 40 : len + 2));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule